// File: doc/BRIEF.md
# External Memory Write Strobe Sequencer

This block turns internal write requests into write cycles on an asynchronous external memory bus. The bus has a 22-bit address, a 16-bit data bus, four memory-bank selects, an I/O-space select and a boot-space select. A requester presents a target space, an address, a data word and a wait count on a valid/ready handshake. The block then drives the select, the active-low write strobe, the address and the data-bus enable, and raises a one-tick done pulse when the cycle is over.

The block runs on a tick at twice the memory-interface clock rate, so one tick is half a memory-clock period. Every strobe edge falls on a tick boundary. An access is always aligned to the start of a memory-clock period. It can be stretched by a programmed wait count, by an external acknowledge input, or by both. The acknowledge input passes through a two-stage synchroniser and is examined only on ticks that close a memory-clock period. An optional write-hold setting keeps the data driven for one extra memory-clock period after the strobe rises. A minimum count of strobe-high ticks is enforced between back-to-back strobes.

Top module: `emc_write_ctrl`

## Requirements
- R1: While reset is held and in the first tick after it is released, every select output and `wr_n` read 1, and `data_oe`, `data_o` and `done` read 0.
- R2: Exactly one select is low for the whole of an access and none is low otherwise. `req_space` codes 0..3 drive `ms_n` bit 0..3 low, code 4 drives `ioms_n` low, and codes 5, 6 and 7 drive `bms_n` low.
- R3: The select goes low in the tick after the request is accepted. `wr_n` falls exactly one tick later. While `wr_n` is low, `addr_o` and `data_o` carry the address and data word that were latched at acceptance.
- R4: With `cfg_mode` 0 (wait states only), `wr_n` stays low for 2*(1+W) ticks, where W is the `req_wait` value latched at acceptance.
- R5: With `cfg_mode` 1 (acknowledge only) and `cfg_ack_en` 1, the base strobe is 2 ticks long. Counting strobe ticks from 0, acknowledge is examined at the last base tick and after that only at odd ticks. A change on `ack_i` driven during tick r becomes visible from tick r+2. The first examined tick j that sees acknowledge high is followed by exactly four more low ticks, which gives a strobe of j+5 ticks.
- R6: With `cfg_mode` 2 or 3 (wait states and acknowledge) and `cfg_ack_en` 1, the base strobe is 2*(1+W) ticks. The acknowledge rule of R5 then applies from the last base tick.
- R7: With `cfg_ack_en` 0, mode codes 1, 2 and 3 behave as mode 0. The strobe is 2*(1+W) ticks whatever level `ack_i` holds.
- R8: The select rises one tick after `wr_n` rises. `data_oe` stays high for 1 tick after `wr_n` rises when `cfg_hold` is 0, and for 3 ticks when it is 1. `data_o` reads 0 whenever `data_oe` is 0.
- R9: `data_oe` rises in the same tick that `wr_n` falls.
- R10: `req_ready` is low from acceptance until the end of the access. `done` is high for exactly one tick, and that tick is the first tick in which `data_oe` is low again.
- R11: Between the rise of one strobe and the fall of the next, `wr_n` stays high for at least GAP_HALF ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate tick clock (two ticks per memory-clock period) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this tick when valid |
| req_space | input | 3 | Target space code |
| req_addr | input | 22 | Write address |
| req_data | input | 16 | Write data word |
| req_wait | input | 3 | Programmed wait count W |
| cfg_mode | input | 2 | Stretch mode: 0 wait, 1 acknowledge, 2/3 both |
| cfg_ack_en | input | 1 | Acknowledge usage enable |
| cfg_hold | input | 1 | Write-hold extension enable |
| ack_i | input | 1 | Asynchronous acknowledge, low holds the access |
| ms_n | output | 4 | Active-low memory-bank selects |
| ioms_n | output | 1 | Active-low I/O-space select |
| bms_n | output | 1 | Active-low boot-space select |
| wr_n | output | 1 | Active-low write strobe |
| addr_o | output | 22 | Bus address |
| data_o | output | 16 | Bus data, 0 while not enabled |
| data_oe | output | 1 | Data-bus drive enable |
| done | output | 1 | One-tick completion pulse |

## Verification
The hardest case to reach is an acknowledge release that lands near a decision tick. There the synchroniser latency and the odd-tick sampling decide whether the strobe gains a further memory-clock period. The stimulus holds acknowledge low before the request. It then releases it at every strobe tick from 0 to 9, for both acknowledge-using modes and for two wait counts, so that every alignment of release tick against decision tick is covered. Back-to-back requests with a gap setting larger than the natural idle time make the gap limit bind.

// File: rtl/emc_pkg.sv
package emc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_ACKWAIT,
      ST_TAIL,
      ST_POST,
      ST_HOLD
   } emc_state_e;

   localparam logic [1:0] MODE_WAIT = 2'd0;
   localparam logic [1:0] MODE_ACK  = 2'd1;

   localparam int unsigned TAIL_TICKS = 4;
   localparam int unsigned HOLD_TICKS = 2;

endpackage

// File: rtl/emc_ack_sync.sv
module emc_ack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   output logic ack_s
);

   logic [STAGES-1:0] chain_q;

   initial begin
      if (STAGES < 2) $error("emc_ack_sync: STAGES must be at least 2");
   end

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= ack_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign ack_s = chain_q[STAGES-1];

endmodule

// File: rtl/emc_sel_decode.sv
module emc_sel_decode #(
   parameter int unsigned NUM_MS  = 4,
   parameter int unsigned SPACE_W = 3
) (
   input  logic               active,
   input  logic [SPACE_W-1:0] space,
   output logic [NUM_MS-1:0]  ms_n,
   output logic               ioms_n,
   output logic               bms_n
);

   localparam logic [SPACE_W-1:0] IO_CODE = SPACE_W'(NUM_MS);

   initial begin
      if ((2 ** SPACE_W) < (NUM_MS + 2))
         $error("emc_sel_decode: SPACE_W too narrow for NUM_MS + 2 codes");
   end

   genvar g;
   generate
      for (g = 0; g < NUM_MS; g++) begin : g_bank
         assign ms_n[g] = !(active && (space == SPACE_W'(g)));
      end
   endgenerate

   assign ioms_n = !(active && (space == IO_CODE));
   assign bms_n  = !(active && (space > IO_CODE));

endmodule

// File: rtl/emc_wr_seq.sv
module emc_wr_seq
   import emc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 22,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned SPACE_W  = 3,
   parameter int unsigned WAIT_W   = 3,
   parameter int unsigned GAP_HALF = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SPACE_W-1:0] req_space,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic [WAIT_W-1:0]  req_wait,
   input  logic [1:0]         cfg_mode,
   input  logic               cfg_ack_en,
   input  logic               cfg_hold,
   input  logic               ack_s,
   output logic               cs_act,
   output logic [SPACE_W-1:0] space_q,
   output logic [ADDR_W-1:0]  addr_q,
   output logic [DATA_W-1:0]  data_out,
   output logic               data_oe,
   output logic               wr_n,
   output logic               done
);

   localparam int unsigned CNT_W = WAIT_W + 2;
   localparam int unsigned GAP_W = $clog2(GAP_HALF + 1) + 1;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TAIL = CNT_W'(TAIL_TICKS);
   localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_TICKS);
   localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_HALF);

   initial begin
      if (WAIT_W < 1)   $error("emc_wr_seq: WAIT_W must be at least 1");
      if (GAP_HALF < 1) $error("emc_wr_seq: GAP_HALF must be at least 1");
   end

   emc_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [WAIT_W-1:0] weff_q;
   logic              ack_on_q;
   logic              hold_q;
   logic              phase_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q;
   logic              gap_ok;
   logic              accept;
   logic              strobe_act;
   logic [CNT_W-1:0]  base_len;

   // free-running half-period phase: 0 opens a memory-clock period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= !phase_q;
   end

   // count strobe-high ticks since the last strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_q <= GAP_MAX;
      else if (strobe_act)       gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_W'(1);
   end

   assign gap_ok    = (32'(gap_q) + 2) >= GAP_HALF;
   assign req_ready = (state_q == ST_IDLE) && !phase_q && gap_ok;
   assign accept    = req_valid && req_ready;
   assign base_len  = {1'b0, weff_q, 1'b0} + CNT_W'(2);

   // capture the request and its stretch configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         space_q  <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         weff_q   <= '0;
         ack_on_q <= 1'b0;
         hold_q   <= 1'b0;
      end else if (accept) begin
         space_q  <= req_space;
         addr_q   <= req_addr;
         data_q   <= req_data;
         ack_on_q <= cfg_ack_en && (cfg_mode != MODE_WAIT);
         weff_q   <= (cfg_ack_en && (cfg_mode == MODE_ACK)) ? '0 : req_wait;
         hold_q   <= cfg_hold;
      end
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) state_d = ST_SETUP;
         end
         ST_SETUP: begin
            state_d = ST_STROBE;
            cnt_d   = base_len;
         end
         ST_STROBE: begin
            if (cnt_q == CNT_ONE) begin
               if (!ack_on_q) begin
                  state_d = ST_POST;
               end else if (ack_s) begin
                  state_d = ST_TAIL;
                  cnt_d   = CNT_TAIL;
               end else begin
                  state_d = ST_ACKWAIT;
               end
            end else begin
               cnt_d = cnt_q - CNT_ONE;
            end
         end
         ST_ACKWAIT: begin
            if (phase_q && ack_s) begin
               state_d = ST_TAIL;
               cnt_d   = CNT_TAIL;
            end
         end
         ST_TAIL: begin
            if (cnt_q == CNT_ONE) state_d = ST_POST;
            else                  cnt_d   = cnt_q - CNT_ONE;
         end
         ST_POST: begin
            if (hold_q) begin
               state_d = ST_HOLD;
               cnt_d   = CNT_HOLD;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_HOLD: begin
            if (cnt_q == CNT_ONE) state_d = ST_IDLE;
            else                  cnt_d   = cnt_q - CNT_ONE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      end
   end

   assign strobe_act = (state_q == ST_STROBE) || (state_q == ST_ACKWAIT) ||
                       (state_q == ST_TAIL);
   assign cs_act     = strobe_act || (state_q == ST_SETUP) || (state_q == ST_POST);
   assign data_oe    = strobe_act || (state_q == ST_POST) || (state_q == ST_HOLD);
   assign wr_n       = !strobe_act;
   assign data_out   = data_oe ? data_q : '0;
   assign done       = done_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_ACK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_n) && ack_on_q) |-> $past(ack_s, 5)); // R5

   AST_OE_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_oe) |-> done); // R10

endmodule

// File: rtl/emc_write_ctrl.sv
module emc_write_ctrl #(
   parameter int unsigned ADDR_W     = 22,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_MS     = 4,
   parameter int unsigned SPACE_W    = 3,
   parameter int unsigned WAIT_W     = 3,
   parameter int unsigned SYNC_STAGE = 2,
   parameter int unsigned GAP_HALF   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SPACE_W-1:0] req_space,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic [WAIT_W-1:0]  req_wait,
   input  logic [1:0]         cfg_mode,
   input  logic               cfg_ack_en,
   input  logic               cfg_hold,
   input  logic               ack_i,
   output logic [NUM_MS-1:0]  ms_n,
   output logic               ioms_n,
   output logic               bms_n,
   output logic               wr_n,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [DATA_W-1:0]  data_o,
   output logic               data_oe,
   output logic               done
);

   localparam int unsigned RUN_W = $clog2(GAP_HALF + 1) + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GAP_HALF);

   logic               ack_s;
   logic               cs_act;
   logic [SPACE_W-1:0] space_q;
   logic               sel_any;
   logic [RUN_W-1:0]   hi_run_q;

   emc_ack_sync #(.STAGES(SYNC_STAGE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .ack_i (ack_i),
      .ack_s (ack_s)
   );

   emc_wr_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SPACE_W  (SPACE_W),
      .WAIT_W   (WAIT_W),
      .GAP_HALF (GAP_HALF)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_space  (req_space),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .req_wait   (req_wait),
      .cfg_mode   (cfg_mode),
      .cfg_ack_en (cfg_ack_en),
      .cfg_hold   (cfg_hold),
      .ack_s      (ack_s),
      .cs_act     (cs_act),
      .space_q    (space_q),
      .addr_q     (addr_o),
      .data_out   (data_o),
      .data_oe    (data_oe),
      .wr_n       (wr_n),
      .done       (done)
   );

   emc_sel_decode #(.NUM_MS(NUM_MS), .SPACE_W(SPACE_W)) u_dec (
      .active (cs_act),
      .space  (space_q),
      .ms_n   (ms_n),
      .ioms_n (ioms_n),
      .bms_n  (bms_n)
   );

   assign sel_any = (~ms_n != '0) || !ioms_n || !bms_n;

   // independent run counter of strobe-high ticks for the spacing check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hi_run_q <= RUN_MAX;
      else if (!wr_n)               hi_run_q <= '0;
      else if (hi_run_q != RUN_MAX) hi_run_q <= hi_run_q + RUN_W'(1);
   end

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~ms_n, ~ioms_n, ~bms_n}) <= 1); // R2

   AST_SEL_LEADS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> ($past(sel_any) && sel_any)); // R3

   AST_SEL_TRAILS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> sel_any); // R8

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> $stable(addr_o)); // R3

   AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> (hi_run_q >= RUN_MAX)); // R11

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!data_oe && !sel_any)); // R10

endmodule

// File: tb/tb_emc_write_ctrl.sv
module tb_emc_write_ctrl;

   localparam int GAP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_space = '0;
   logic [21:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic [2:0]  req_wait = '0;
   logic [1:0]  cfg_mode = '0;
   logic        cfg_ack_en = 1'b0;
   logic        cfg_hold = 1'b0;
   logic        ack_i = 1'b1;
   logic [3:0]  ms_n;
   logic        ioms_n, bms_n, wr_n, data_oe, done;
   logic [21:0] addr_o;
   logic [15:0] data_o;

   int total = 0;
   int bad = 0;
   int seq_no = 0;
   bit finished = 1'b0;
   int hi_run = 1000;

   emc_write_ctrl #(.GAP_HALF(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_space(req_space), .req_addr(req_addr), .req_data(req_data),
      .req_wait(req_wait), .cfg_mode(cfg_mode), .cfg_ack_en(cfg_ack_en),
      .cfg_hold(cfg_hold), .ack_i(ack_i), .ms_n(ms_n), .ioms_n(ioms_n),
      .bms_n(bms_n), .wr_n(wr_n), .addr_o(addr_o), .data_o(data_o),
      .data_oe(data_oe), .done(done)
   );

   always #4 clk = !clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // R11: count strobe-high ticks and check at every fall
   always @(negedge clk) begin
      if (rst_n) begin
         if (!wr_n) begin
            if (hi_run > 0 && hi_run < 1000)
               chk(hi_run >= GAP, "R11 gap before strobe", hi_run, GAP);
            hi_run = 0;
         end else if (hi_run < 1000) begin
            hi_run++;
         end
      end
   end

   // sp: space, w: wait, md: mode, aen: ack enable, hld: hold, r: ack release tick (<0 high from start)
   task automatic run_acc(input int sp, input int w, input int md, input bit aen,
                          input bit hld, input int r, input bit settle);
      int n, n_wf, n_wr, n_cr, n_orise, n_of, n_dn, wait_cnt;
      int weff, base, j, exp_len;
      bit ackact, bus_err, rdy_err, sel_err;
      logic [3:0] exp_ms;
      logic exp_io, exp_bm;
      logic [21:0] a;
      logic [15:0] d;
      string tag;
      seq_no++;
      a = 22'((sp * 7919 + w * 131 + seq_no * 4099) & 22'h3fffff);
      d = 16'((seq_no * 40503 + sp * 17 + w) & 16'hffff);
      ack_i = (r < 0) ? 1'b1 : 1'b0;
      if (settle) repeat (3) @(negedge clk);
      req_space = 3'(sp); req_addr = a; req_data = d; req_wait = 3'(w);
      cfg_mode = 2'(md); cfg_ack_en = aen; cfg_hold = hld;
      req_valid = 1'b1;
      wait_cnt = 0;
      while (!req_ready && wait_cnt < 50) begin
         @(negedge clk);
         wait_cnt++;
      end
      chk(req_ready, "R10 ready reached", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      exp_ms = 4'hf; exp_io = 1'b1; exp_bm = 1'b1;
      if (sp < 4) exp_ms[sp] = 1'b0;
      else if (sp == 4) exp_io = 1'b0;
      else exp_bm = 1'b0;
      n_wf = -1; n_wr = -1; n_cr = -1; n_orise = -1; n_of = -1; n_dn = -1;
      bus_err = 0; rdy_err = 0; sel_err = 0;
      for (n = 0; n < 150 && n_dn < 0; n++) begin
         if (n_wf < 0 && !wr_n) n_wf = n;
         if (n_orise < 0 && data_oe) n_orise = n;
         if (n_wf >= 0 && n_wr < 0 && wr_n) n_wr = n;
         if (n_wr >= 0 && n_cr < 0 && ms_n == 4'hf && ioms_n && bms_n) n_cr = n;
         if (n_orise >= 0 && n_of < 0 && !data_oe) n_of = n;
         if (done) n_dn = n;
         if (!wr_n && (addr_o != a || data_o != d || !data_oe)) bus_err = 1;
         if (n_cr < 0 && (ms_n != exp_ms || ioms_n != exp_io || bms_n != exp_bm)) sel_err = 1;
         if (req_ready && n_dn < 0) rdy_err = 1;
         if (n_dn < 0) begin
            if (n_wf >= 0 && n_wr < 0 && r >= 0 && (n - n_wf) == r) ack_i = 1'b1;
            @(negedge clk);
         end
      end
      ackact = aen && (md != 0);
      weff = (ackact && md == 1) ? 0 : w;
      base = 2 * (1 + weff);
      if (!ackact) exp_len = base;
      else begin
         j = base - 1;
         if (r >= 0 && r + 2 > j) j = r + 2;
         if ((j % 2) == 0) j++;
         exp_len = j + 5;
      end
      if (!ackact) tag = (md == 0) ? "R4 wait strobe length" : "R7 ack disabled length";
      else tag = (md == 1) ? "R5 ack strobe length" : "R6 both strobe length";
      chk(sel_err == 0, "R2 select decode", int'(sel_err), 0);
      chk(n_wf == 1, "R3 select leads strobe", n_wf, 1);
      chk(bus_err == 0, "R3 bus values", int'(bus_err), 0);
      chk((n_wr - n_wf) == exp_len, tag, n_wr - n_wf, exp_len);
      chk(n_cr == n_wr + 1, "R8 select trails strobe", n_cr, n_wr + 1);
      chk(n_of == n_wr + (hld ? 3 : 1), "R8 data hold", n_of, n_wr + (hld ? 3 : 1));
      chk(data_o == 16'h0, "R8 bus idle value", int'(data_o), 0);
      chk(n_orise == n_wf, "R9 enable with strobe", n_orise, n_wf);
      chk(n_dn == n_of && n_dn >= 0, "R10 done tick", n_dn, n_of);
      chk(rdy_err == 0, "R10 ready while busy", int'(rdy_err), 0);
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ms_n == 4'hf && ioms_n && bms_n, "R1 selects idle in reset", int'(ms_n), 15);
      chk(wr_n && !data_oe && !done && data_o == 16'h0, "R1 strobe idle in reset",
          int'({wr_n, data_oe, done}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ms_n == 4'hf && wr_n && !data_oe && !done && data_o == 16'h0,
          "R1 idle after reset", int'(ms_n), 15);
      // R2 R4 R8: exhaustive space x wait sweep, wait-only, hold alternating, back to back
      for (int sp = 0; sp < 8; sp++)
         for (int w = 0; w < 8; w++)
            run_acc(sp, w, 0, 1'b1, 1'(sp + w), -1, 1'b0);
      // R5 R6: acknowledge released at every strobe tick
      for (int md = 1; md <= 3; md++)
         for (int w = 0; w < 4; w += 3)
            for (int r = -1; r < 10; r++)
               run_acc(md + 2, w, md, 1'b1, 1'(r), r, 1'b1);
      // R7: acknowledge disabled and held low
      for (int md = 1; md <= 3; md++)
         for (int w = 0; w < 4; w++)
            run_acc(w, w, md, 1'b0, 1'b0, 99, 1'b1);
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule